// File: doc/BRIEF.md
# Watchdog Timer with Two-Word Kick Sequence

This block is a watchdog timer that sits on a simple single-cycle register bus. Software writes a timeout exponent and an enable bit into a configuration register. The block holds these values in a shadow copy. The shadow copy becomes active only when software completes a kick. A kick is two fixed magic words, written in order to two separate registers. Once the timer is active, the counter runs one step per clock. Software must repeat the kick before the counter reaches 2^(delay+1) cycles. If it does not, the block emits a single-cycle reset request.

A kick that is malformed also raises a reset request. A malformed kick is any of these: a wrong word, the second word sent without the first, or the first word sent twice. The block also raises a reset request when software writes to a soft-reset register, and when an external user-reset input is asserted. Each request stores a 3-bit cause code. Only the power-on reset input clears this code, so software can read after a restart why the last reset happened.

Top module: `wdg_top`

## Requirements
- R1: After power-on reset (rst_n low), rst_req is 0, the cause code reads 0 (hard reset) and the configuration reads 0. The counter is disabled, so no request follows until software enables it.
- R2: A write to offset 0x04 stores bit 31 (enable) and bits [4:0] (delay) into the shadow configuration. A read of offset 0x04 returns those two fields, and every other bit reads 0.
- R3: A configuration write has no effect on counting until a valid kick. With enable written but no kick, no rst_req pulse ever appears.
- R4: A valid kick is 0xABCD1234 written to offset 0x08, followed by 0x4321DCBA written to offset 0x0C. The kick copies the shadow configuration to the active one. With the timer active, rst_req is high for exactly one cycle, 2^(delay+1) cycles after the clock edge that takes the second kick write. Cause code 1 is stored at the same time. After that the count restarts, so the pulses repeat every 2^(delay+1) cycles. The boundary value delay=0 gives a period of 2 cycles.
- R5: A valid kick clears the counter to zero. A kick before expiry therefore moves the next request to 2^(delay+1) cycles after that kick.
- R6: Any value other than 0xABCD1234 written to offset 0x08 raises rst_req in the cycle after the write and stores cause code 2. So does any value other than 0x4321DCBA written to offset 0x0C after a correct first word.
- R7: A write to offset 0x0C that is not preceded by a correct first word raises rst_req and stores cause code 2. A second 0xABCD1234 written to offset 0x08 while the first word is already pending does the same. Either of these faults clears the pending first word.
- R8: Writing a value with bit 0 set to offset 0x00 raises rst_req in the cycle after the write and stores cause code 3. Writing a value with bit 0 clear there has no effect.
- R9: The user_rst input raises rst_req in the cycle after it is sampled high and stores cause code 4.
- R10: The block's own reset requests never clear the cause code. Reading offset 0x08 returns the most recent cause in bits [2:0], with all other bits 0. Only rst_n returns the code to 0.
- R11: Clearing the enable bit does not stop an active timer until a valid kick follows. Requests continue on schedule until that kick, and none occur after it.
- R12: When several request sources fire in the same cycle, rst_req pulses once. The stored cause follows the priority user reset (4) > soft reset (3) > incorrect kick (2) > timeout (1). A valid kick in the expiry cycle cancels the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the counter advances once per cycle |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| user_rst | input | 1 | External user-reset request |
| rst_req | output | 1 | Reset request pulse to the system |

## Verification
Soft-reset writes, incorrect kicks and user_rst all produce their rst_req pulse in the cycle right after the edge that samples them. A timeout pulse comes exactly 2^(delay+1) edges after the edge that takes the second kick word. For each stimulus, the driver computes the edge count at which the pulse is due and pushes it to a scoreboard queue. A monitor compares every pulse it sees, one nanosecond after the falling edge, against the head of that queue. This means a pulse that is early, late, extra or two cycles wide is reported as a mismatch. Bus reads are combinational, so the bench reads the cause code and the configuration after each pulse has been scored, before the next stimulus.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [3:0] OFF_SWRST = 4'h0;
  localparam logic [3:0] OFF_CFG   = 4'h4;
  localparam logic [3:0] OFF_KEY1  = 4'h8;
  localparam logic [3:0] OFF_KEY2  = 4'hC;

  localparam logic [31:0] KEY_FIRST  = 32'hABCD_1234;
  localparam logic [31:0] KEY_SECOND = 32'h4321_DCBA;

  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_POR     = 3'd0,
    CAUSE_EXPIRE  = 3'd1,
    CAUSE_BADKICK = 3'd2,
    CAUSE_SWRST   = 3'd3,
    CAUSE_EXTRST  = 3'd4
  } cause_e;
endpackage

// File: rtl/wdg_rst_sync.sv
module wdg_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [SYNC_STAGES-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/wdg_kick.sv
module wdg_kick
  import wdg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int DELAY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic               sh_en,
  output logic [DELAY_W-1:0] sh_delay,
  output logic               armed,
  output logic               valid_kick,
  output logic               bad_kick,
  output logic               soft_req
);
  localparam logic [DATA_W-1:0] KEY1 = DATA_W'(KEY_FIRST);
  localparam logic [DATA_W-1:0] KEY2 = DATA_W'(KEY_SECOND);

  logic               wr_swrst, wr_cfg, wr_key1, wr_key2;
  logic               key1_ok, key2_ok;
  logic               armed_q, armed_d, armed_ce;
  logic               sh_en_q;
  logic [DELAY_W-1:0] sh_delay_q;

  // address decode
  always_comb begin
    wr_swrst = bus_wr && (bus_addr == ADDR_W'(OFF_SWRST));
    wr_cfg   = bus_wr && (bus_addr == ADDR_W'(OFF_CFG));
    wr_key1  = bus_wr && (bus_addr == ADDR_W'(OFF_KEY1));
    wr_key2  = bus_wr && (bus_addr == ADDR_W'(OFF_KEY2));
    key1_ok  = (bus_wdata == KEY1);
    key2_ok  = (bus_wdata == KEY2);
  end

  // kick sequence next state
  always_comb begin
    valid_kick = wr_key2 && key2_ok && armed_q;
    bad_kick   = (wr_key1 && (!key1_ok || armed_q)) ||
                 (wr_key2 && (!key2_ok || !armed_q));
    soft_req   = wr_swrst && bus_wdata[0];
    armed_ce   = wr_key1 || wr_key2;
    armed_d    = wr_key1 && key1_ok && !armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_ce) begin
      armed_q <= armed_d;
    end
  end

  // shadow configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en_q    <= 1'b0;
      sh_delay_q <= '0;
    end else if (wr_cfg) begin
      sh_en_q    <= bus_wdata[DATA_W-1];
      sh_delay_q <= bus_wdata[DELAY_W-1:0];
    end
  end

  assign sh_en    = sh_en_q;
  assign sh_delay = sh_delay_q;
  assign armed    = armed_q;
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int DELAY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_kick,
  input  logic               sh_en,
  input  logic [DELAY_W-1:0] sh_delay,
  output logic               act_en,
  output logic               expire
);
  localparam int CNT_W = (1 << DELAY_W) + 1;
  localparam int SH_W  = $clog2(CNT_W) + 1;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic               act_en_q;
  logic [DELAY_W-1:0] act_delay_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   last_cnt;
  logic               hit;

  // last count value before expiry: 2^(delay+1)-1
  always_comb begin
    last_cnt = ALL_ONES >> (SH_W'(CNT_W - 1) - SH_W'(act_delay_q));
    hit      = act_en_q && (cnt_q == last_cnt);
    expire   = hit && !valid_kick;
    if (valid_kick || !act_en_q || hit) cnt_d = '0;
    else                                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en_q    <= 1'b0;
      act_delay_q <= '0;
    end else if (valid_kick) begin
      act_en_q    <= sh_en;
      act_delay_q <= sh_delay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign act_en = act_en_q;
endmodule

// File: rtl/wdg_cause.sv
module wdg_cause
  import wdg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               user_rst,
  input  logic               soft_req,
  input  logic               bad_kick,
  input  logic               expire,
  output logic               rst_req,
  output logic [CAUSE_W-1:0] cause
);
  logic   any_req;
  cause_e sel;
  logic   rst_req_q;
  cause_e cause_q;

  always_comb begin
    any_req = user_rst || soft_req || bad_kick || expire;
    if (user_rst)      sel = CAUSE_EXTRST;
    else if (soft_req) sel = CAUSE_SWRST;
    else if (bad_kick) sel = CAUSE_BADKICK;
    else               sel = CAUSE_EXPIRE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= any_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cause_q <= CAUSE_POR;
    else if (any_req) cause_q <= sel;
  end

  assign rst_req = rst_req_q;
  assign cause   = cause_q;
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int DELAY_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              user_rst,
  output logic              rst_req
);
  logic               rst_sync_n;
  logic               sh_en, armed, valid_kick, bad_kick, soft_req;
  logic [DELAY_W-1:0] sh_delay;
  logic               act_en, expire;
  logic [CAUSE_W-1:0] cause_q;

  wdg_rst_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  wdg_kick #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DELAY_W(DELAY_W)) u_kick (
    .clk(clk), .rst_n(rst_sync_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sh_en(sh_en), .sh_delay(sh_delay), .armed(armed),
    .valid_kick(valid_kick), .bad_kick(bad_kick), .soft_req(soft_req)
  );

  wdg_count #(.DELAY_W(DELAY_W)) u_count (
    .clk(clk), .rst_n(rst_sync_n), .valid_kick(valid_kick), .sh_en(sh_en),
    .sh_delay(sh_delay), .act_en(act_en), .expire(expire)
  );

  wdg_cause u_cause (
    .clk(clk), .rst_n(rst_sync_n), .user_rst(user_rst), .soft_req(soft_req),
    .bad_kick(bad_kick), .expire(expire), .rst_req(rst_req), .cause(cause_q)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_CFG)) begin
      bus_rdata[DATA_W-1]    = sh_en;
      bus_rdata[DELAY_W-1:0] = sh_delay;
    end else if (bus_addr == ADDR_W'(OFF_KEY1)) begin
      bus_rdata[CAUSE_W-1:0] = cause_q;
    end
  end
endmodule

// File: rtl/wdg_sva.sv
module wdg_sva
  import wdg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               user_rst,
  input logic               rst_req,
  input logic [CAUSE_W-1:0] cause,
  input logic               act_en,
  input logic               armed
);
  a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_en && !user_rst && !bus_wr) |=> !rst_req);

  a_r6_bad_first_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_KEY1) && bus_wdata != DATA_W'(KEY_FIRST))
    |=> rst_req);

  a_r7_second_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_KEY2) && !armed) |=> rst_req);

  a_r8_soft_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(OFF_SWRST) && bus_wdata[0] && !user_rst)
    |=> (rst_req && cause == CAUSE_SWRST));

  a_r9_user_cause: assert property (@(posedge clk) disable iff (!rst_n)
    user_rst |=> (rst_req && cause == CAUSE_EXTRST));

  a_r10_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_req |-> $stable(cause));

  a_r10_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cause <= CAUSE_EXTRST);
endmodule

bind wdg_top wdg_sva #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_sync_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .user_rst(user_rst), .rst_req(rst_req),
  .cause(cause_q), .act_en(act_en), .armed(armed)
);

// File: tb/tb_wdg_top.sv
module tb_wdg_top;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        user_rst;
  logic        rst_req;

  int unsigned cyc;
  int unsigned last_cyc;
  int unsigned expq[$];
  int          checks;
  int          fails;
  int          seen;
  bit          finished;

  localparam logic [31:0] K1 = 32'hABCD_1234;
  localparam logic [31:0] K2 = 32'h4321_DCBA;

  wdg_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .user_rst(user_rst),
    .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compares each pulse against the scoreboard queue
  always begin
    @(negedge clk);
    #1;
    if (rst_n && rst_req) begin
      seen++;
      if (expq.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R4 unexpected rst_req: actual cycle %0d expected none", cyc);
      end else begin
        int unsigned e;
        e = expq.pop_front();
        check(cyc == e, "R4", "rst_req cycle", cyc, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    last_cyc = cyc;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #2 v = bus_rdata;
  endtask

  task automatic kick();
    wr(4'h8, K1);
    wr(4'hC, K2);
  endtask

  task automatic wait_cyc(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic cause_is(input int exp, input string req);
    logic [31:0] v;
    rd(4'h8, v);
    check(v == 32'(exp), req, "cause read", v, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    logic [31:0] v;
    int unsigned k, s;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; user_rst = 1'b0;
    repeat (3) @(negedge clk);
    check(rst_req == 1'b0, "R1", "rst_req in reset", rst_req, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cause_is(0, "R1");
    rd(4'h4, v);
    check(v == 0, "R1", "cfg after reset", v, 0);

    // R2: shadow write and readback, junk bits dropped
    wr(4'h4, 32'h8000_0F03);
    rd(4'h4, v);
    check(v == 32'h8000_0003, "R2", "cfg readback", v, 32'h8000_0003);

    // R3: no kick yet, so no request
    repeat (40) @(negedge clk);
    check(seen == 0, "R3", "pulses without kick", seen, 0);

    // R4: delay 3 -> 16 cycles
    kick();
    k = last_cyc;
    expq.push_back(k + 16);
    wait_cyc(k + 18);
    check(seen == 1, "R4", "timeout pulse count", seen, 1);
    cause_is(1, "R4");

    // R5: re-kick postpones expiry
    kick();
    repeat (10) @(negedge clk);
    kick();
    k = last_cyc;
    expq.push_back(k + 16);
    wait_cyc(k + 17);
    check(seen == 2, "R5", "pulse after rekick", seen, 2);

    // R11: disable written but not committed -> still fires
    wr(4'h4, 32'h0);
    expq.push_back(k + 32);
    wait_cyc(k + 33);
    check(seen == 3, "R11", "pulse before commit", seen, 3);
    kick();
    s = seen;
    repeat (40) @(negedge clk);
    check(seen == s, "R11", "pulses after disable kick", seen, s);
    rd(4'h4, v);
    check(v == 0, "R11", "cfg readback", v, 0);

    // R6: wrong first word
    wr(4'h8, 32'h0000_1234);
    expq.push_back(last_cyc);
    cause_is(2, "R6");
    // R8: soft reset
    wr(4'h0, 32'h1);
    expq.push_back(last_cyc);
    cause_is(3, "R8");
    // R8: bit 0 clear ignored
    s = seen;
    wr(4'h0, 32'hFFFF_FFFE);
    repeat (2) @(negedge clk);
    check(seen == s, "R8", "pulses for zero write", seen, s);
    cause_is(3, "R8");
    // R6: good first, wrong second
    wr(4'h8, K1);
    wr(4'hC, 32'h4321_DCBB);
    expq.push_back(last_cyc);
    cause_is(2, "R6");
    // R7: second without first
    wr(4'h0, 32'h1);
    expq.push_back(last_cyc);
    cause_is(3, "R10");
    wr(4'hC, K2);
    expq.push_back(last_cyc);
    cause_is(2, "R7");
    // R7: first word twice, then pending cleared
    wr(4'h8, K1);
    wr(4'h8, K1);
    expq.push_back(last_cyc);
    wr(4'hC, K2);
    expq.push_back(last_cyc);
    cause_is(2, "R7");
    // R9: user reset
    @(negedge clk);
    user_rst = 1'b1;
    @(negedge clk);
    user_rst = 1'b0;
    expq.push_back(cyc);
    cause_is(4, "R9");
    // R12: user and bad kick together -> one pulse, cause 4
    wr(4'h0, 32'h1);
    expq.push_back(last_cyc);
    cause_is(3, "R12");
    s = seen;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = 32'hDEAD_BEEF; user_rst = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; user_rst = 1'b0;
    expq.push_back(cyc);
    cause_is(4, "R12");
    check(seen == s + 1, "R12", "single pulse", seen, s + 1);

    // R4 boundary: delay 0 -> period 2
    wr(4'h4, 32'h8000_0000);
    kick();
    k = last_cyc;
    expq.push_back(k + 2);
    expq.push_back(k + 4);
    wait_cyc(k + 4);
    #3 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(expq.size() == 0, "R4", "queue drained", expq.size(), 0);
    // R10: only power-on reset clears the cause
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cause_is(0, "R10");
    rd(4'h4, v);
    check(v == 0, "R1", "cfg after second reset", v, 0);
    s = seen;
    repeat (20) @(negedge clk);
    check(seen == s, "R1", "no pulses after reset", seen, s);
    summary();
  end
endmodule